// File: doc/BRIEF.md
# Unified In-Order-Allocated Load/Store Queue

This block tracks every in-flight memory operation of an out-of-order core in one circular queue kept in program order. An operation takes the tail slot when it is dispatched and leaves from the head when the core retires it. Its effective address arrives later, whenever address generation finishes, and is written back by slot index. Address generation often finishes out of program order.

Loads are released to memory with a conservative rule. A load may go only when its own address is known and every store ahead of it in program order has a known address that differs from the load's. An all-pairs address comparator, qualified by each slot's distance from the head, computes this. When several loads qualify in the same cycle, the one nearest the head goes first. Stores never issue early. A store is sent to memory only when it retires from the head.

Top module: `lsq_unified`

## Requirements
- R1: After reset the queue is empty: `empty`=1, `full`=0, `disp_ready`=1, no load issue and no store commit.
- R2: An accepted dispatch takes the slot shown on `disp_idx`, which then advances by one modulo DEPTH. `full` is 1 exactly when DEPTH operations are held.
- R3: While `full` is 1, `disp_ready` is 0 and a dispatch request is dropped without creating an entry. After DEPTH retirements the queue is empty again.
- R4: An address writeback to a held slot records the address. Writebacks may come in any order. An issued load reports its slot, its recorded address and its tag.
- R5: A load does not issue while any older store still has an unknown address.
- R6: A load does not issue while an older store holds the same address. A store with a different address, and a younger store, do not hold it back.
- R7: At most one load issues per cycle. Among eligible loads the one closest to the head wins. Each load issues only once.
- R8: `retire` removes the head entry only when that entry is complete: a store with a known address, or a load that has already issued. Otherwise, or when the queue is empty, the pulse is ignored.
- R9: A retired store raises `st_commit_valid` for exactly the next cycle, with its address and tag. A retired load produces no commit.
- R10: `empty` is 1 exactly when no operation is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | Dispatch request |
| disp_is_store | input | 1 | 1 = store, 0 = load |
| disp_tag | input | TAG_W | Core tag for the operation |
| disp_ready | output | 1 | Dispatch will be accepted |
| disp_idx | output | IDX_W | Slot the next dispatch will take |
| agen_valid | input | 1 | Address writeback strobe |
| agen_idx | input | IDX_W | Slot receiving the address |
| agen_addr | input | ADDR_W | Effective address |
| retire | input | 1 | Retire pulse for the head entry |
| ld_issue_valid | output | 1 | A load is sent to memory this cycle |
| ld_issue_idx | output | IDX_W | Slot of the issued load |
| ld_issue_addr | output | ADDR_W | Address of the issued load |
| ld_issue_tag | output | TAG_W | Tag of the issued load |
| st_commit_valid | output | 1 | A retired store is written to memory |
| st_commit_addr | output | ADDR_W | Address of the committed store |
| st_commit_tag | output | TAG_W | Tag of the committed store |
| full | output | 1 | All slots occupied |
| empty | output | 1 | No slot occupied |

## Verification
The assertions check a set of invariants on every cycle. An issued load is always a held load with a known address, issued for the first time, with no older store of unknown address ahead of it. A commit always follows a retire pulse. A refused dispatch or a retire on an incomplete head leaves the pointers unchanged. `full` and `empty` are never set together. Other properties need whole sequences, so only the bench scenarios show them: that the winner among several eligible loads is the oldest, that a same-address older store holds a load until that store retires, and that an ignored retire shifts which later retire produces a store commit. The same applies to correct age order once the pointers wrap around the queue.

// File: rtl/lsq_pkg.sv
package lsq_pkg;
  // Distance of a slot from the head, in program order (0 = oldest).
  function automatic int unsigned slot_age(int unsigned slot, int unsigned head,
                                           int unsigned depth);
    return (slot + depth - head) % depth;
  endfunction

  // True when slot a precedes slot b in program order.
  function automatic logic is_older(int unsigned a, int unsigned b,
                                    int unsigned head, int unsigned depth);
    return slot_age(a, head, depth) < slot_age(b, head, depth);
  endfunction
endpackage

// File: rtl/lsq_dep_matrix.sv
module lsq_dep_matrix
  import lsq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 16,
  localparam int IDX_W = $clog2(DEPTH)
)(
  input  logic [IDX_W-1:0]             head,
  input  logic [DEPTH-1:0]             ent_v,
  input  logic [DEPTH-1:0]             ent_st,
  input  logic [DEPTH-1:0]             ent_av,
  input  logic [DEPTH-1:0]             ent_iss,
  input  logic [DEPTH-1:0][ADDR_W-1:0] ent_addr,
  output logic [DEPTH-1:0]             load_ok
);
  // Row i: the candidate load; column j: a possible older store hazard.
  for (genvar i = 0; i < DEPTH; i++) begin : g_row
    logic [DEPTH-1:0] hazard;
    for (genvar j = 0; j < DEPTH; j++) begin : g_col
      logic older;
      assign older = is_older(j, i, int'(head), DEPTH);
      assign hazard[j] = ent_v[j] & ent_st[j] & older &
                         (~ent_av[j] | (ent_addr[j] == ent_addr[i]));
    end
    assign load_ok[i] = ent_v[i] & ~ent_st[i] & ent_av[i] & ~ent_iss[i] & ~|hazard;
  end
endmodule

// File: rtl/lsq_oldest_pick.sv
module lsq_oldest_pick #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
)(
  input  logic [IDX_W-1:0] head,
  input  logic [DEPTH-1:0] req,
  output logic             gnt_valid,
  output logic [IDX_W-1:0] gnt_idx
);
  logic [IDX_W-1:0] slot;

  // Scan from youngest to oldest so the last hit, the oldest, wins.
  always_comb begin
    gnt_valid = 1'b0;
    gnt_idx   = head;
    slot      = head;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      slot = head + IDX_W'(k);
      if (req[slot]) begin
        gnt_valid = 1'b1;
        gnt_idx   = slot;
      end
    end
  end
endmodule

// File: rtl/lsq_unified.sv
module lsq_unified
  import lsq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 16,
  parameter int TAG_W  = 6,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              disp_valid,
  input  logic              disp_is_store,
  input  logic [TAG_W-1:0]  disp_tag,
  output logic              disp_ready,
  output logic [IDX_W-1:0]  disp_idx,
  input  logic              agen_valid,
  input  logic [IDX_W-1:0]  agen_idx,
  input  logic [ADDR_W-1:0] agen_addr,
  input  logic              retire,
  output logic              ld_issue_valid,
  output logic [IDX_W-1:0]  ld_issue_idx,
  output logic [ADDR_W-1:0] ld_issue_addr,
  output logic [TAG_W-1:0]  ld_issue_tag,
  output logic              st_commit_valid,
  output logic [ADDR_W-1:0] st_commit_addr,
  output logic [TAG_W-1:0]  st_commit_tag,
  output logic              full,
  output logic              empty
);
  initial begin
    if ((1 << IDX_W) != DEPTH) $error("DEPTH must be a power of two");
  end

  logic [IDX_W-1:0]             head_q, tail_q;
  logic [CNT_W-1:0]             cnt_q;
  logic [DEPTH-1:0]             v_q, st_q, av_q, iss_q;
  logic [DEPTH-1:0][ADDR_W-1:0] addr_q;
  logic [DEPTH-1:0][TAG_W-1:0]  tag_q;
  logic                         cm_v;
  logic [ADDR_W-1:0]            cm_a;
  logic [TAG_W-1:0]             cm_t;

  // Named internal events
  logic             disp_ok, head_done, ret_ok, pick_v;
  logic [IDX_W-1:0] pick_idx;
  logic [DEPTH-1:0] load_ok;

  assign full      = (cnt_q == CNT_W'(DEPTH));
  assign empty     = (cnt_q == '0);
  assign disp_ok   = disp_valid & ~full;
  assign head_done = v_q[head_q] & (st_q[head_q] ? av_q[head_q] : iss_q[head_q]);
  assign ret_ok    = retire & head_done;

  lsq_dep_matrix #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_matrix (
    .head(head_q), .ent_v(v_q), .ent_st(st_q), .ent_av(av_q),
    .ent_iss(iss_q), .ent_addr(addr_q), .load_ok(load_ok)
  );

  lsq_oldest_pick #(.DEPTH(DEPTH)) u_pick (
    .head(head_q), .req(load_ok), .gnt_valid(pick_v), .gnt_idx(pick_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0; tail_q <= '0; cnt_q <= '0;
      v_q <= '0; st_q <= '0; av_q <= '0; iss_q <= '0;
      addr_q <= '0; tag_q <= '0;
      cm_v <= 1'b0; cm_a <= '0; cm_t <= '0;
    end else begin
      cm_v <= ret_ok & st_q[head_q];
      if (ret_ok) begin
        cm_a         <= addr_q[head_q];
        cm_t         <= tag_q[head_q];
        v_q[head_q]  <= 1'b0;
        head_q       <= head_q + 1'b1;
      end
      if (pick_v) iss_q[pick_idx] <= 1'b1;
      if (agen_valid && v_q[agen_idx]) begin
        av_q[agen_idx]   <= 1'b1;
        addr_q[agen_idx] <= agen_addr;
      end
      if (disp_ok) begin
        v_q[tail_q]   <= 1'b1;
        st_q[tail_q]  <= disp_is_store;
        av_q[tail_q]  <= 1'b0;
        iss_q[tail_q] <= 1'b0;
        tag_q[tail_q] <= disp_tag;
        tail_q        <= tail_q + 1'b1;
      end
      cnt_q <= cnt_q + CNT_W'(disp_ok) - CNT_W'(ret_ok);
    end
  end

  assign disp_ready      = ~full;
  assign disp_idx        = tail_q;
  assign ld_issue_valid  = pick_v;
  assign ld_issue_idx    = pick_idx;
  assign ld_issue_addr   = addr_q[pick_idx];
  assign ld_issue_tag    = tag_q[pick_idx];
  assign st_commit_valid = cm_v;
  assign st_commit_addr  = cm_a;
  assign st_commit_tag   = cm_t;

  // Independent scan for older stores with unknown address (assertion aid).
  logic older_unknown;
  always_comb begin
    older_unknown = 1'b0;
    for (int j = 0; j < DEPTH; j++)
      if (v_q[j] && st_q[j] && !av_q[j] &&
          is_older(j, int'(pick_idx), int'(head_q), DEPTH))
        older_unknown = 1'b1;
  end

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
  assert_full_refuse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && full) |=> $stable(tail_q));
  assert_issue_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ld_issue_valid |-> (v_q[ld_issue_idx] && !st_q[ld_issue_idx] &&
                        av_q[ld_issue_idx] && !iss_q[ld_issue_idx]));
  assert_no_unknown_older_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ld_issue_valid |-> !older_unknown);
  assert_issue_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ld_issue_valid |=> !(ld_issue_valid && ld_issue_idx == $past(ld_issue_idx)));
  assert_retire_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && !head_done) |=> $stable(head_q));
  assert_commit_after_retire_R9: assert property (@(posedge clk) disable iff (!rst_n)
    st_commit_valid |-> $past(retire));
  assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));
endmodule

// File: tb/sim_lsq_unified.sv
`timescale 1ns/1ps
module sim_lsq_unified;
  localparam int D = 8;
  localparam int AW = 16;
  localparam int TW = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic disp_valid = 0, disp_is_store = 0, agen_valid = 0, retire = 0;
  logic [TW-1:0] disp_tag = '0;
  logic [2:0] agen_idx = '0;
  logic [AW-1:0] agen_addr = '0;
  logic disp_ready, ld_issue_valid, st_commit_valid, full, empty;
  logic [2:0] disp_idx, ld_issue_idx;
  logic [AW-1:0] ld_issue_addr, st_commit_addr;
  logic [TW-1:0] ld_issue_tag, st_commit_tag;

  always #10 clk = ~clk;

  lsq_unified #(.DEPTH(D), .ADDR_W(AW), .TAG_W(TW)) u0 (
    .clk, .rst_n, .disp_valid, .disp_is_store, .disp_tag, .disp_ready, .disp_idx,
    .agen_valid, .agen_idx, .agen_addr, .retire, .ld_issue_valid, .ld_issue_idx,
    .ld_issue_addr, .ld_issue_tag, .st_commit_valid, .st_commit_addr,
    .st_commit_tag, .full, .empty);

  int checks = 0, errors = 0;
  bit done = 0;

  // Reference model state
  bit mv[D], ms[D], ma[D], mi[D];
  logic [AW-1:0] mad[D];
  logic [TW-1:0] mt[D];
  int mh = 0, mtl = 0, mc = 0;
  bit exp_cv = 0;
  logic [AW-1:0] exp_ca = '0;
  logic [TW-1:0] exp_ct = '0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int age(int s);
    return (s - mh + D) % D;
  endfunction

  function automatic bit may_go(int s);
    if (!mv[s] || ms[s] || !ma[s] || mi[s]) return 0;
    for (int j = 0; j < D; j++)
      if (mv[j] && ms[j] && age(j) < age(s) && (!ma[j] || mad[j] == mad[s])) return 0;
    return 1;
  endfunction

  function automatic int oldest_ready();
    for (int k = 0; k < D; k++)
      if (may_go((mh + k) % D)) return (mh + k) % D;
    return -1;
  endfunction

  // One cycle: compare outputs, drive inputs, advance the model.
  task automatic cyc(bit dv, bit ds, logic [TW-1:0] dt, bit av, int ai,
                     logic [AW-1:0] aa, bit rt);
    int p;
    bit rok, dok;
    p = oldest_ready();
    chk(ld_issue_valid == (p >= 0), "R7", "issue valid", ld_issue_valid, p >= 0);
    if (p >= 0 && ld_issue_valid) begin
      chk(ld_issue_idx == p[2:0], "R7", "issue slot", ld_issue_idx, p);
      chk(ld_issue_addr == mad[p], "R4", "issue addr", ld_issue_addr, mad[p]);
      chk(ld_issue_tag == mt[p], "R4", "issue tag", ld_issue_tag, mt[p]);
    end
    chk(full == (mc == D), "R2", "full", full, mc == D);
    chk(empty == (mc == 0), "R10", "empty", empty, mc == 0);
    chk(disp_ready == (mc != D), "R3", "disp_ready", disp_ready, mc != D);
    chk(disp_idx == mtl[2:0], "R2", "disp_idx", disp_idx, mtl);
    chk(st_commit_valid == exp_cv, "R9", "commit valid", st_commit_valid, exp_cv);
    if (exp_cv && st_commit_valid) begin
      chk(st_commit_addr == exp_ca, "R9", "commit addr", st_commit_addr, exp_ca);
      chk(st_commit_tag == exp_ct, "R9", "commit tag", st_commit_tag, exp_ct);
    end
    disp_valid = dv; disp_is_store = ds; disp_tag = dt;
    agen_valid = av; agen_idx = ai[2:0]; agen_addr = aa; retire = rt;
    rok = rt && mv[mh] && (ms[mh] ? ma[mh] : mi[mh]);
    dok = dv && (mc < D);
    exp_cv = rok && ms[mh];
    if (rok) begin
      exp_ca = mad[mh]; exp_ct = mt[mh];
      mv[mh] = 0; mh = (mh + 1) % D; mc--;
    end
    if (p >= 0) mi[p] = 1;
    if (av && mv[ai]) begin ma[ai] = 1; mad[ai] = aa; end
    if (dok) begin
      mv[mtl] = 1; ms[mtl] = ds; ma[mtl] = 0; mi[mtl] = 0; mt[mtl] = dt;
      mtl = (mtl + 1) % D; mc++;
    end
    @(negedge clk);
  endtask

  task automatic idle(bit rt);
    cyc(0, 0, '0, 0, 0, '0, rt);
  endtask

  task automatic agen(int i, logic [AW-1:0] a);
    cyc(0, 0, '0, 1, i, a, 0);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      chk(0, "ALL", "watchdog expired", 0, 1);
      summary();
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(empty == 1 && full == 0 && disp_ready == 1, "R1", "flags after reset",
        {empty, full, disp_ready}, 3'b101);
    chk(!ld_issue_valid && !st_commit_valid, "R1", "outputs after reset",
        {ld_issue_valid, st_commit_valid}, 0);

    // Directed hazard scenario: st0 ld1 ld2 st3 ld4
    cyc(1, 1, 6'd1, 0, 0, '0, 0);
    cyc(1, 0, 6'd2, 0, 0, '0, 0);
    cyc(1, 0, 6'd3, 0, 0, '0, 0);
    cyc(1, 1, 6'd4, 0, 0, '0, 0);
    cyc(1, 0, 6'd5, 0, 0, '0, 0);
    agen(1, 16'h0040);
    agen(4, 16'h0080);
    chk(!ld_issue_valid, "R5", "older store unknown blocks", ld_issue_valid, 0);
    agen(0, 16'h0040);
    chk(!ld_issue_valid, "R6", "same-address older store blocks", ld_issue_valid, 0);
    agen(3, 16'h0090);
    chk(ld_issue_valid && ld_issue_idx == 3'd4, "R6", "different address passes",
        ld_issue_idx, 4);
    agen(2, 16'h0040);
    chk(!ld_issue_valid, "R6", "match still blocks slot 2", ld_issue_valid, 0);
    idle(1);  // retire st0
    chk(st_commit_valid && st_commit_addr == 16'h0040 && st_commit_tag == 6'd1,
        "R9", "store commit", st_commit_addr, 16'h0040);
    chk(ld_issue_valid && ld_issue_idx == 3'd1, "R7", "oldest of two wins",
        ld_issue_idx, 1);
    idle(1);  // head load not issued yet: ignored
    chk(!st_commit_valid, "R9", "commit lasts one cycle", st_commit_valid, 0);
    chk(ld_issue_valid && ld_issue_idx == 3'd2, "R7", "next load follows",
        ld_issue_idx, 2);
    idle(1);  // ld1
    idle(1);  // ld2
    chk(!st_commit_valid, "R8", "ignored retire kept head", st_commit_valid, 0);
    idle(1);  // st3
    chk(st_commit_valid && st_commit_addr == 16'h0090 && st_commit_tag == 6'd4,
        "R8", "store retires after ignored pulse", st_commit_addr, 16'h0090);
    idle(1);  // ld4
    chk(empty == 1, "R10", "empty after last retire", empty, 1);
    idle(1);  // retire on empty
    chk(!st_commit_valid, "R9", "load retire has no commit", st_commit_valid, 0);
    chk(empty == 1, "R8", "retire on empty ignored", empty, 1);

    // Fill test with pointer wrap
    for (int k = 0; k < D; k++) cyc(1, 0, TW'(20 + k), 0, 0, '0, 0);
    chk(full == 1 && disp_ready == 0, "R2", "full after DEPTH dispatches",
        {full, disp_ready}, 2'b10);
    cyc(1, 0, 6'd63, 0, 0, '0, 0);
    chk(full == 1, "R3", "refused dispatch", full, 1);
    for (int k = D - 1; k >= 0; k--) agen((mh + k) % D, AW'(16'h0200 + k * 4));
    idle(0);
    idle(0);
    for (int k = 0; k < D - 1; k++) idle(1);
    chk(empty == 0, "R3", "one entry left", empty, 0);
    idle(1);
    chk(empty == 1, "R3", "refused op never held", empty, 1);

    // Constrained random phase
    for (int n = 0; n < 3000; n++) begin
      bit dv, ds, av, rt;
      int ai, st;
      logic [AW-1:0] aa;
      dv = ($urandom % 100) < 50;
      ds = ($urandom % 100) < 40;
      rt = ($urandom % 100) < 40;
      aa = AW'(16'h0100 + ($urandom % 4) * 4);
      av = 0; ai = 0;
      if (($urandom % 100) < 60) begin
        st = $urandom % D;
        for (int k = 0; k < D; k++)
          if (!av && mv[(st + k) % D] && !ma[(st + k) % D]) begin
            av = 1; ai = (st + k) % D;
          end
      end
      cyc(dv, ds, TW'($urandom), av, ai, aa, rt);
    end
    idle(0);
    if (!done) begin
      done = 1;
      summary();
    end
  end
endmodule